// File: doc/BRIEF.md
# Processor Parity Check Aggregator

This block collects the hardware consistency checks of a small processor datapath. Each cycle it looks at the operand registers, the main-storage address, the data read from storage, the current control word, the storage-protect buffer output and a duplicated ALU result. It turns any failure into a latched indicator, one for each check, and a single machine-check line. Every check has its own qualifier. A check that is not qualified in a given cycle is skipped, because some sources carry no parity or because some cycles are exempt.

A mode input chooses what happens after a failure. In stop mode the block raises a clock-stop request. In record-only mode it only latches the indicator. The datapath and the recovery microcode sit outside this block. They see only the indicator vector, the machine-check line and the clock-stop request.

Top module: `pchk_aggregator`

## Requirements
- R1: Parity is odd: each 8-bit byte together with its parity bit must hold an odd count of ones. When a qualified check sees an even count in any of its bytes, that check's indicator is set at the next rising clock edge. Multi-byte fields check every byte on its own.
- R2: The A operand check (indicator bit 0) and the B operand check (bit 1) run only in a cycle where the register loads (`x_load`=1) and the source either carries parity (`x_src_par`=1) or is local storage (`x_from_ls`=1). In any other cycle bad parity on that register has no effect.
- R3: The storage address check (bit 2) runs when `addr_valid`=1, except when `addr_after_bom`=1, which marks the address following a branch-on-mask word.
- R4: The storage data check (bit 3) runs in every cycle where `sdata_valid`=1. This includes the second cycle of a storage word.
- R5: The control-word check (bit 4) runs when `cw_valid`=1 and `cw_second`=0. It is skipped in the second cycle of a storage word.
- R6: When `alu_valid`=1, the ALU check (bit 5) fails in either of two cases: the result wire and the zero-test wire differ in any bit, or either wire fails odd parity against the predicted parity bits `alu_pred`.
- R7: The storage-protect check (bit 6) runs when `sp_valid`=1.
- R8: `rst_n`=0 clears all indicators. Once set, an indicator stays set until the next reset.
- R9: `mchk` is 1 exactly when at least one indicator is set.
- R10: If `stop_mode`=1 in a cycle where any check fails, `clk_stop` rises at the same edge that latches the indicator and stays high until reset. A failure detected while `stop_mode`=0 never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears indicators |
| stop_mode | input | 1 | 1: failures request a clock stop; 0: record only |
| a_data | input | 8*OPND_BYTES | A register contents |
| a_par | input | OPND_BYTES | A register parity bits |
| a_load | input | 1 | A register loaded this cycle |
| a_src_par | input | 1 | Source of A byte carries parity |
| a_from_ls | input | 1 | Source of A byte is local storage |
| b_data | input | 8*OPND_BYTES | B register contents |
| b_par | input | OPND_BYTES | B register parity bits |
| b_load | input | 1 | B register loaded this cycle |
| b_src_par | input | 1 | Source of B byte carries parity |
| b_from_ls | input | 1 | Source of B byte is local storage |
| addr | input | 8*ADDR_BYTES | Main-storage address |
| addr_par | input | ADDR_BYTES | Address parity bits |
| addr_valid | input | 1 | Main-storage access this cycle |
| addr_after_bom | input | 1 | Address follows a branch-on-mask word |
| sdata | input | 8*SDATA_BYTES | Data read from storage |
| sdata_par | input | SDATA_BYTES | Storage data parity bits |
| sdata_valid | input | 1 | Storage data present |
| cw | input | 8*CW_BYTES | Control word |
| cw_par | input | CW_BYTES | Control word parity bits |
| cw_valid | input | 1 | Machine cycle active |
| cw_second | input | 1 | Second cycle of a storage word |
| alu_res | input | ALU_W | ALU result wire |
| alu_zt | input | ALU_W | ALU zero-test wire |
| alu_pred | input | ALU_W/8 | Predicted result parity bits |
| alu_valid | input | 1 | ALU output meaningful |
| sp_data | input | 8*SP_BYTES | Storage-protect buffer output |
| sp_par | input | SP_BYTES | Storage-protect parity bits |
| sp_valid | input | 1 | Storage-protect buffer read |
| ind | output | 7 | Sticky indicators, bit order as in R2 to R7 |
| mchk | output | 1 | Machine-check summary |
| clk_stop | output | 1 | Clock-stop request |

## Verification
The assertions rely on the qualifiers being clean, known levels at every clock edge. They also assume that `stop_mode` is meaningful only in cycles where a failure is possible. The stimulus changes every input only at the falling edge. Between checks it returns every qualifier to 0 and restores correct odd parity. Each test therefore corrupts only the fields it names, so the expected indicator change comes from that corruption alone.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
   localparam int BYTE_W   = 8;
   localparam int CHK_A    = 0;
   localparam int CHK_B    = 1;
   localparam int CHK_ADDR = 2;
   localparam int CHK_SDAT = 3;
   localparam int CHK_CW   = 4;
   localparam int CHK_ALU  = 5;
   localparam int CHK_SP   = 6;
   localparam int NUM_CHK  = 7;
   typedef logic [NUM_CHK-1:0] chk_vec_t;
endpackage

// File: rtl/pchk_par_chk.sv
module pchk_par_chk
   import pchk_pkg::*;
#(
   parameter int NBYTES = 1
) (
   input  logic                     en,
   input  logic [NBYTES*BYTE_W-1:0] data,
   input  logic [NBYTES-1:0]        par,
   output logic                     err
);
   localparam int DW = NBYTES * BYTE_W;

   if (NBYTES < 1) begin : g_bad_n
      $error("pchk_par_chk: NBYTES must be at least 1");
   end

   logic [NBYTES-1:0] byte_bad;

   if (NBYTES == 1) begin : g_single
      // odd parity: nine bits with an even count of ones is a failure
      assign byte_bad[0] = ~(^{data[DW-1:0], par[0]});
   end else begin : g_multi
      for (genvar i = 0; i < NBYTES; i++) begin : g_byte
         assign byte_bad[i] = ~(^{data[i*BYTE_W +: BYTE_W], par[i]});
      end
   end

   assign err = en & (|byte_bad);
endmodule

// File: rtl/pchk_alu_2w.sv
module pchk_alu_2w
   import pchk_pkg::*;
#(
   parameter int ALU_W = 16
) (
   input  logic                      en,
   input  logic [ALU_W-1:0]          res,
   input  logic [ALU_W-1:0]          zt,
   input  logic [ALU_W/BYTE_W-1:0]   pred,
   output logic                      err
);
   localparam int NB = ALU_W / BYTE_W;

   if (ALU_W < BYTE_W || (ALU_W % BYTE_W) != 0) begin : g_bad_w
      $error("pchk_alu_2w: ALU_W must be a positive multiple of the byte width");
   end

   logic res_bad, zt_bad, wires_differ;

   pchk_par_chk #(.NBYTES(NB)) i_res_par (
      .en  (1'b1),
      .data(res),
      .par (pred),
      .err (res_bad)
   );

   pchk_par_chk #(.NBYTES(NB)) i_zt_par (
      .en  (1'b1),
      .data(zt),
      .par (pred),
      .err (zt_bad)
   );

   logic [NB-1:0] byte_diff;
   for (genvar i = 0; i < NB; i++) begin : g_cmp
      assign byte_diff[i] = |(res[i*BYTE_W +: BYTE_W] ^ zt[i*BYTE_W +: BYTE_W]);
   end
   assign wires_differ = |byte_diff;

   assign err = en & (wires_differ | res_bad | zt_bad);
endmodule

// File: rtl/pchk_ind_reg.sv
module pchk_ind_reg
   import pchk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     stop_mode,
   input  chk_vec_t hit,
   output chk_vec_t ind,
   output logic     mchk,
   output logic     clk_stop
);
   chk_vec_t ind_q;
   logic     stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ind_q  <= '0;
         stop_q <= 1'b0;
      end else begin
         ind_q <= ind_q | hit;
         if (stop_mode && (|hit)) stop_q <= 1'b1;
      end
   end

   assign ind      = ind_q;
   assign mchk     = |ind_q;
   assign clk_stop = stop_q;

   p_hit_latched_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((ind & $past(hit)) == $past(hit)));
   p_ind_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(ind) & ~ind) == '0));
   p_mchk_never_falls_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(mchk));
   p_stop_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && (|hit)) |=> clk_stop);
   p_record_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_mode && !clk_stop) |=> !clk_stop);
   p_stop_implies_mchk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop |-> mchk);
endmodule

// File: rtl/pchk_aggregator.sv
module pchk_aggregator
   import pchk_pkg::*;
#(
   parameter int OPND_BYTES  = 1,
   parameter int ADDR_BYTES  = 2,
   parameter int SDATA_BYTES = 2,
   parameter int CW_BYTES    = 2,
   parameter int ALU_W       = 16,
   parameter int SP_BYTES    = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          stop_mode,
   input  logic [OPND_BYTES*BYTE_W-1:0]  a_data,
   input  logic [OPND_BYTES-1:0]         a_par,
   input  logic                          a_load,
   input  logic                          a_src_par,
   input  logic                          a_from_ls,
   input  logic [OPND_BYTES*BYTE_W-1:0]  b_data,
   input  logic [OPND_BYTES-1:0]         b_par,
   input  logic                          b_load,
   input  logic                          b_src_par,
   input  logic                          b_from_ls,
   input  logic [ADDR_BYTES*BYTE_W-1:0]  addr,
   input  logic [ADDR_BYTES-1:0]         addr_par,
   input  logic                          addr_valid,
   input  logic                          addr_after_bom,
   input  logic [SDATA_BYTES*BYTE_W-1:0] sdata,
   input  logic [SDATA_BYTES-1:0]        sdata_par,
   input  logic                          sdata_valid,
   input  logic [CW_BYTES*BYTE_W-1:0]    cw,
   input  logic [CW_BYTES-1:0]           cw_par,
   input  logic                          cw_valid,
   input  logic                          cw_second,
   input  logic [ALU_W-1:0]              alu_res,
   input  logic [ALU_W-1:0]              alu_zt,
   input  logic [ALU_W/BYTE_W-1:0]       alu_pred,
   input  logic                          alu_valid,
   input  logic [SP_BYTES*BYTE_W-1:0]    sp_data,
   input  logic [SP_BYTES-1:0]           sp_par,
   input  logic                          sp_valid,
   output logic [NUM_CHK-1:0]            ind,
   output logic                          mchk,
   output logic                          clk_stop
);
   if (OPND_BYTES < 1 || ADDR_BYTES < 1 || SDATA_BYTES < 1 ||
       CW_BYTES < 1 || SP_BYTES < 1) begin : g_bad_bytes
      $error("pchk_aggregator: every byte count must be at least 1");
   end

   // qualifiers
   logic q_a, q_b, q_addr, q_sdat, q_cw, q_sp, q_alu;
   assign q_a    = a_load & (a_src_par | a_from_ls);
   assign q_b    = b_load & (b_src_par | b_from_ls);
   assign q_addr = addr_valid & ~addr_after_bom;
   assign q_sdat = sdata_valid;
   assign q_cw   = cw_valid & ~cw_second;
   assign q_sp   = sp_valid;
   assign q_alu  = alu_valid;

   chk_vec_t hit;

   pchk_par_chk #(.NBYTES(OPND_BYTES)) i_chk_a (
      .en(q_a), .data(a_data), .par(a_par), .err(hit[CHK_A]));
   pchk_par_chk #(.NBYTES(OPND_BYTES)) i_chk_b (
      .en(q_b), .data(b_data), .par(b_par), .err(hit[CHK_B]));
   pchk_par_chk #(.NBYTES(ADDR_BYTES)) i_chk_addr (
      .en(q_addr), .data(addr), .par(addr_par), .err(hit[CHK_ADDR]));
   pchk_par_chk #(.NBYTES(SDATA_BYTES)) i_chk_sdat (
      .en(q_sdat), .data(sdata), .par(sdata_par), .err(hit[CHK_SDAT]));
   pchk_par_chk #(.NBYTES(CW_BYTES)) i_chk_cw (
      .en(q_cw), .data(cw), .par(cw_par), .err(hit[CHK_CW]));
   pchk_alu_2w #(.ALU_W(ALU_W)) i_chk_alu (
      .en(q_alu), .res(alu_res), .zt(alu_zt), .pred(alu_pred),
      .err(hit[CHK_ALU]));
   pchk_par_chk #(.NBYTES(SP_BYTES)) i_chk_sp (
      .en(q_sp), .data(sp_data), .par(sp_par), .err(hit[CHK_SP]));

   pchk_ind_reg i_ind (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_mode(stop_mode),
      .hit      (hit),
      .ind      (ind),
      .mchk     (mchk),
      .clk_stop (clk_stop)
   );

   p_a_exempt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !a_load |=> ind[CHK_A] == $past(ind[CHK_A]));
   p_b_exempt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !b_load |=> ind[CHK_B] == $past(ind[CHK_B]));
   p_addr_bom_r3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_after_bom |=> ind[CHK_ADDR] == $past(ind[CHK_ADDR]));
   p_cw_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cw_second |=> ind[CHK_CW] == $past(ind[CHK_CW]));
   p_alu_wires_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_valid && (alu_res != alu_zt)) |=> ind[CHK_ALU]);
   p_sp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sp_valid |=> ind[CHK_SP] == $past(ind[CHK_SP]));
endmodule

// File: tb/test_pchk_aggregator.sv
module test_pchk_aggregator;
   localparam int CLK_P = 10;

   typedef struct {
      logic [6:0] ind;
      logic       mchk;
      logic       stp;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_mode;
   logic [7:0]  a_data, b_data, sp_data;
   logic        a_par, b_par, sp_par;
   logic        a_load, a_src_par, a_from_ls, b_load, b_src_par, b_from_ls;
   logic [15:0] addr, sdata, cw, alu_res, alu_zt;
   logic [1:0]  addr_par, sdata_par, cw_par, alu_pred;
   logic        addr_valid, addr_after_bom, sdata_valid, cw_valid, cw_second;
   logic        alu_valid, sp_valid;
   logic [6:0]  ind;
   logic        mchk, clk_stop;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];
   logic [6:0] exp_ind = '0;
   logic       exp_stp = 1'b0;
   logic       done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pchk_aggregator i_pchk_aggregator (.*);

   function automatic logic op8(logic [7:0] b);
      return ~^b;
   endfunction

   function automatic logic [1:0] op16(logic [15:0] w);
      return {op8(w[15:8]), op8(w[7:0])};
   endfunction

   // all qualifiers low, all parity correct
   task automatic quiet();
      stop_mode = 1'b0;
      a_load = 0; a_src_par = 0; a_from_ls = 0;
      b_load = 0; b_src_par = 0; b_from_ls = 0;
      addr_valid = 0; addr_after_bom = 0; sdata_valid = 0;
      cw_valid = 0; cw_second = 0; alu_valid = 0; sp_valid = 0;
      a_data = 8'h5a; b_data = 8'h13; sp_data = 8'h0f;
      addr = 16'h1234; sdata = 16'hbeef; cw = 16'h0ff1;
      alu_res = 16'h3c71; alu_zt = 16'h3c71;
      fixpar();
   endtask

   task automatic fixpar();
      a_par = op8(a_data); b_par = op8(b_data); sp_par = op8(sp_data);
      addr_par = op16(addr); sdata_par = op16(sdata); cw_par = op16(cw);
      alu_pred = op16(alu_res);
   endtask

   // driver: called after inputs are set at the falling edge
   task automatic tick(input logic [6:0] hit, input string tag);
      exp_t e;
      exp_ind = exp_ind | hit;
      if (stop_mode && hit != '0) exp_stp = 1'b1;
      e.ind = exp_ind; e.mchk = |exp_ind; e.stp = exp_stp; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      quiet();
   endtask

   task automatic check(input logic ok, input string tag, input logic [8:0] act,
                        input logic [8:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%b exp=%b", tag, act, exp);
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({clk_stop, mchk, ind} === {e.stp, e.mchk, e.ind}, e.tag,
                  {clk_stop, mchk, ind}, {e.stp, e.mchk, e.ind});
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #(CLK_P/4);
      exp_ind = '0; exp_stp = 1'b0;
      check({clk_stop, mchk, ind} === 9'b0, "R8 reset clears",
            {clk_stop, mchk, ind}, 9'b0);
      @(negedge clk);
      rst_n = 1'b1;
      quiet();
   endtask

   initial begin
      quiet();
      repeat (2) @(negedge clk);
      do_reset();

      tick(7'h00, "R1 idle no change");
      a_load = 1; a_src_par = 1; tick(7'h00, "R1 good A parity");
      a_load = 1; a_par = ~a_par; tick(7'h00, "R2 A unparitied source ignored");
      b_load = 1; b_from_ls = 0; b_src_par = 0; b_par = ~b_par;
      tick(7'h00, "R2 B unparitied source ignored");
      a_par = ~a_par; tick(7'h00, "R2 A not loaded ignored");
      a_load = 1; a_from_ls = 1; a_par = ~a_par;
      tick(7'h01, "R2 A local storage checked, R10 record only, R9 mchk");
      tick(7'h00, "R8 indicator sticky");
      do_reset();

      b_load = 1; b_src_par = 1; b_par = ~b_par; tick(7'h02, "R2 B checked");
      addr_valid = 1; addr_after_bom = 1; addr_par[1] = ~addr_par[1];
      tick(7'h00, "R3 address after branch-on-mask ignored");
      addr_valid = 1; addr_par[1] = ~addr_par[1];
      tick(7'h04, "R3 address high byte bad");
      do_reset();

      sdata_valid = 1; sdata_par[1] = ~sdata_par[1];
      cw_valid = 1; cw_second = 1; cw_par[0] = ~cw_par[0];
      tick(7'h08, "R4 data checked in second cycle, R5 cw skipped");
      cw_valid = 1; cw_par[1] = ~cw_par[1]; tick(7'h10, "R5 cw checked");
      do_reset();

      alu_valid = 1; tick(7'h00, "R6 ALU wires agree");
      alu_valid = 1; alu_zt = alu_res ^ 16'h0300;
      tick(7'h20, "R6 ALU wires differ with good parity");
      do_reset();
      alu_valid = 1; alu_pred[0] = ~alu_pred[0];
      tick(7'h20, "R6 ALU predicted parity mismatch");
      do_reset();
      alu_valid = 1; alu_zt = alu_res ^ 16'h0001; alu_pred = op16(alu_zt);
      tick(7'h20, "R6 one wire fails parity");
      do_reset();

      sp_par = ~sp_par; tick(7'h00, "R7 storage protect not read ignored");
      sp_valid = 1; sp_par = ~sp_par; tick(7'h40, "R7 storage protect bad");
      do_reset();

      stop_mode = 1; tick(7'h00, "R10 stop mode without error");
      stop_mode = 1; sdata_valid = 1; sdata_par[0] = ~sdata_par[0];
      tick(7'h08, "R10 stop request raised");
      tick(7'h00, "R10 stop request sticky");
      do_reset();

      a_load = 1; a_src_par = 1; a_par = ~a_par;
      sp_valid = 1; sp_par = ~sp_par;
      tick(7'h41, "R1 two checks in one cycle");
      sp_valid = 1; sp_par = ~sp_par; stop_mode = 1;
      tick(7'h40, "R10 stop after earlier record-only error");

      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule